// File: doc/BRIEF.md
# Millisecond Periodic Interrupt Timer

This block produces a periodic interrupt for a real-time clock subsystem. A single-cycle strobe arrives once per millisecond. While counting is enabled, the block counts these strobes. When the count reaches a programmed number of milliseconds, the block sets a sticky pending flag and starts the count again from zero. A rate of f Hz is programmed as the truncated quotient 1000/f, so the useful period values are 1 through 1000.

Software writes two registers through a one-cycle write strobe with a select line. The control word holds a count-enable bit, an interrupt-enable bit and a write-one-to-clear bit for the pending flag. The period word holds the interval in milliseconds. Counting and interrupting have separate enables, so the timer can run and set its flag without asserting the interrupt line. Software normally sets or clears both enables in one control write.

The level interrupt output is high while the pending flag is set and the interrupt enable is set. The current count and both enables are visible on output ports.

Top module: `periodic_ms_timer`

## Requirements
- R1: After reset the pending flag, the interrupt, both enables, the millisecond count and the stored period are all zero.
- R2: The count advances by one on each cycle with msTick high while count enable is set and the period is non-zero. In a cycle with neither msTick nor wrEn, msCount does not change.
- R3: With period N (1 to 1000), the count runs 0 to N-1. The N-th tick after a restart sets pendFlag at the same clock edge that returns msCount to 0. With N = 1, every tick matches.
- R4: A stored period of 0 never produces a match, and msCount stays 0 however many ticks arrive.
- R5: Clearing count enable forces msCount to 0 at the same edge, and ticks have no effect while count enable is clear.
- R6: A period write (wrSel = 1, value in wrData[PERIOD_W-1:0]) resets msCount to 0. A tick in the same cycle is discarded, so the next match comes a full new period later.
- R7: irqOut is high exactly when pendFlag and alarmOn are both set. A match with alarmOn clear still sets pendFlag, and irqOut stays low.
- R8: pendFlag stays set until a control write with bit 13 set clears it. A control write with bit 13 clear leaves it unchanged. If a match and a clear arrive in the same cycle, the flag ends up set.
- R9: A control write (wrSel = 0) loads count enable from wrData bit 15 and interrupt enable from wrData bit 14. Both are replaced on every control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle strobe per millisecond |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the control word, 1 selects the period word |
| wrData | input | 16 | Write data |
| irqOut | output | 1 | Level interrupt request |
| pendFlag | output | 1 | Sticky period-match flag |
| countOn | output | 1 | Current count enable |
| alarmOn | output | 1 | Current interrupt enable |
| msCount | output | 10 | Milliseconds counted since the last restart |

## Verification
The properties assume that msTick and wrEn are synchronous single-cycle strobes. The count-stability property relies on the count changing only in a cycle carrying one of them. No assumption is made about how far apart ticks are, so the bench spaces them both back-to-back and with idle cycles between. All inputs are driven on the falling edge and returned to idle right after the rising edge. Every strobe therefore covers exactly one rising edge, and writes are never held across edges.

// File: rtl/pit_pkg.sv
package pit_pkg;

  parameter int CTL_CEN_BIT = 15;
  parameter int CTL_AEN_BIT = 14;
  parameter int CTL_CLR_BIT = 13;

  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_PERIOD = 1'b1
  } pitSel_e;

  typedef struct packed {
    logic runCount;
    logic loadPeriod;
  } pitStrobe_t;

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [2:0] ctlBits,
  input  logic       matchHit,
  output pitStrobe_t strobe,
  output logic       countOn,
  output logic       alarmOn,
  output logic       pendFlag
);

  logic ctlWr;
  logic cenNext;
  logic aenNext;
  logic clrReq;

  assign ctlWr   = wrEn && (pitSel_e'(wrSel) == SEL_CTRL);
  assign cenNext = ctlWr ? ctlBits[2] : countOn;
  assign aenNext = ctlWr ? ctlBits[1] : alarmOn;
  assign clrReq  = ctlWr && ctlBits[0];

  always_comb begin
    strobe.runCount   = cenNext;
    strobe.loadPeriod = wrEn && (pitSel_e'(wrSel) == SEL_PERIOD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countOn  <= 1'b0;
      alarmOn  <= 1'b0;
      pendFlag <= 1'b0;
    end else begin
      countOn <= cenNext;
      alarmOn <= aenNext;
      if (matchHit)
        pendFlag <= 1'b1;
      else if (clrReq)
        pendFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msTick,
  input  pitStrobe_t          strobe,
  input  logic [PERIOD_W-1:0] periodIn,
  output logic                matchHit,
  output logic [PERIOD_W-1:0] msCount
);

  logic [PERIOD_W-1:0] periodReg;
  logic [PERIOD_W-1:0] lastCount;
  logic                periodZero;
  logic                stepOk;

  assign periodZero = (periodReg == '0);
  assign lastCount  = periodReg - 1'b1;
  assign stepOk     = strobe.runCount && !strobe.loadPeriod && msTick && !periodZero;
  assign matchHit   = stepOk && (msCount == lastCount);

  always_ff @(posedge clk) begin
    if (!rstN)
      periodReg <= '0;
    else if (strobe.loadPeriod)
      periodReg <= periodIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      msCount <= '0;
    else if (!strobe.runCount || strobe.loadPeriod)
      msCount <= '0;
    else if (matchHit)
      msCount <= '0;
    else if (stepOk)
      msCount <= msCount + 1'b1;
  end

endmodule

// File: rtl/periodic_ms_timer.sv
module periodic_ms_timer
  import pit_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msTick,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [DATA_W-1:0]   wrData,
  output logic                irqOut,
  output logic                pendFlag,
  output logic                countOn,
  output logic                alarmOn,
  output logic [PERIOD_W-1:0] msCount
);

  pitStrobe_t strobe;
  logic       matchHit;
  logic [2:0] ctlBits;

  assign ctlBits = {wrData[CTL_CEN_BIT], wrData[CTL_AEN_BIT], wrData[CTL_CLR_BIT]};

  generate
    if (PERIOD_W < CTL_CLR_BIT) begin : g_spare
      logic unusedWrBits;
      assign unusedWrBits = ^wrData[CTL_CLR_BIT-1:PERIOD_W];
    end
    if (DATA_W > CTL_CEN_BIT + 1) begin : g_high
      logic unusedHighBits;
      assign unusedHighBits = ^wrData[DATA_W-1:CTL_CEN_BIT+1];
    end
  endgenerate

  pit_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .ctlBits  (ctlBits),
    .matchHit (matchHit),
    .strobe   (strobe),
    .countOn  (countOn),
    .alarmOn  (alarmOn),
    .pendFlag (pendFlag)
  );

  pit_datapath #(.PERIOD_W(PERIOD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .msTick   (msTick),
    .strobe   (strobe),
    .periodIn (wrData[PERIOD_W-1:0]),
    .matchHit (matchHit),
    .msCount  (msCount)
  );

  assign irqOut = pendFlag & alarmOn;

endmodule

// File: rtl/periodic_ms_timer_chk.sv
module periodic_ms_timer_chk #(
  parameter int PERIOD_W = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                msTick,
  input logic                wrEn,
  input logic                irqOut,
  input logic                pendFlag,
  input logic                countOn,
  input logic                alarmOn,
  input logic [PERIOD_W-1:0] msCount
);

  AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!msTick && !wrEn) |=> $stable(msCount)); // R2

  AST_MATCH_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendFlag) |-> (msCount == '0)); // R3

  AST_MATCH_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendFlag) |-> $past(msTick)); // R3

  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !countOn |-> (msCount == '0)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !alarmOn |-> !irqOut); // R7

  AST_IRQ_FROM_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> pendFlag); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pendFlag && !wrEn) |=> pendFlag); // R8

endmodule

bind periodic_ms_timer periodic_ms_timer_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .msTick   (msTick),
  .wrEn     (wrEn),
  .irqOut   (irqOut),
  .pendFlag (pendFlag),
  .countOn  (countOn),
  .alarmOn  (alarmOn),
  .msCount  (msCount)
);

// File: tb/periodic_ms_timer_tb.sv
module periodic_ms_timer_tb;

  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          msTick = 1'b0;
  logic          wrEn = 1'b0;
  logic          wrSel = 1'b0;
  logic [15:0]   wrData = '0;
  logic          irqOut;
  logic          pendFlag;
  logic          countOn;
  logic          alarmOn;
  logic [PW-1:0] msCount;

  always #5 clk = ~clk;

  periodic_ms_timer #(.DATA_W(16), .PERIOD_W(PW)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .msTick   (msTick),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .irqOut   (irqOut),
    .pendFlag (pendFlag),
    .countOn  (countOn),
    .alarmOn  (alarmOn),
    .msCount  (msCount)
  );

  typedef struct {
    string req;
    bit    flag;
    bit    irq;
    bit    cen;
    bit    aen;
    int    cnt;
  } exp_t;

  exp_t  expQ[$];
  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  int mCnt = 0;
  int mPer = 0;
  bit mFlag = 0;
  bit mCen = 0;
  bit mAen = 0;

  function automatic void pushExp();
    exp_t e;
    e.req  = curReq;
    e.flag = mFlag;
    e.irq  = mFlag && mAen;
    e.cen  = mCen;
    e.aen  = mAen;
    e.cnt  = mCnt;
    expQ.push_back(e);
  endfunction

  always begin
    @(negedge clk);
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (pendFlag !== e.flag || irqOut !== e.irq || countOn !== e.cen ||
          alarmOn !== e.aen || int'(msCount) != e.cnt) begin
        errors++;
        $display("FAIL %s: got flag=%0b irq=%0b cen=%0b aen=%0b cnt=%0d, expected flag=%0b irq=%0b cen=%0b aen=%0b cnt=%0d",
                 e.req, pendFlag, irqOut, countOn, alarmOn, msCount,
                 e.flag, e.irq, e.cen, e.aen, e.cnt);
      end
    end
  end

  task automatic step(input bit t, input bit w, input bit s, input logic [15:0] d);
    bit ctl;
    bit per;
    bit nCen;
    bit nAen;
    bit clr;
    bit hit;
    @(negedge clk);
    msTick = t; wrEn = w; wrSel = s; wrData = d;
    ctl  = w && !s;
    per  = w && s;
    nCen = ctl ? d[15] : mCen;
    nAen = ctl ? d[14] : mAen;
    clr  = ctl && d[13];
    hit  = 0;
    if (!nCen || per) mCnt = 0;
    else if (t && mPer != 0) begin
      if (mCnt + 1 == mPer) begin mCnt = 0; hit = 1; end
      else mCnt++;
    end
    if (per) mPer = int'(d[PW-1:0]);
    if (hit) mFlag = 1;
    else if (clr) mFlag = 0;
    mCen = nCen;
    mAen = nAen;
    @(posedge clk);
    #1;
    msTick = 0; wrEn = 0;
    pushExp();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, '0);
  endtask

  task automatic wrCtl(input logic [15:0] d);
    step(0, 1, 0, d);
  endtask

  task automatic wrPer(input int v);
    step(0, 1, 1, 16'(v));
  endtask

  task automatic hardCheck(input string req, input int cnt, input bit flag, input bit irq);
    checks++;
    if (int'(msCount) != cnt || pendFlag !== flag || irqOut !== irq) begin
      errors++;
      $display("FAIL %s: got cnt=%0d flag=%0b irq=%0b, expected cnt=%0d flag=%0b irq=%0b",
               req, msCount, pendFlag, irqOut, cnt, flag, irq);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    curReq = "R1";
    pushExp();
    @(posedge clk); #1;
    hardCheck("R1", 0, 0, 0);

    curReq = "R2";
    ticks(3);
    hardCheck("R2", 0, 0, 0);

    curReq = "R9";
    wrPer(5);
    wrCtl(16'hC000);
    curReq = "R2";
    ticks(4);
    step(0, 0, 0, '0);
    hardCheck("R2", 4, 0, 0);
    curReq = "R3";
    ticks(1);
    hardCheck("R3", 0, 1, 1);

    curReq = "R8";
    wrCtl(16'hC000);
    hardCheck("R8", 0, 1, 1);
    wrCtl(16'hE000);
    hardCheck("R8", 0, 0, 0);

    curReq = "R7";
    wrCtl(16'h8000);
    ticks(5);
    hardCheck("R7", 0, 1, 0);
    wrCtl(16'hC000);
    hardCheck("R7", 0, 1, 1);
    wrCtl(16'hE000);

    curReq = "R6";
    ticks(3);
    step(1, 1, 1, 16'd4);
    hardCheck("R6", 0, 0, 0);
    ticks(3);
    hardCheck("R6", 3, 0, 0);
    ticks(1);
    hardCheck("R6", 0, 1, 1);
    wrCtl(16'hE000);

    curReq = "R5";
    ticks(2);
    wrCtl(16'h4000);
    hardCheck("R5", 0, 0, 0);
    ticks(6);
    hardCheck("R5", 0, 0, 0);
    wrCtl(16'hC000);
    ticks(1);
    hardCheck("R5", 1, 0, 0);

    curReq = "R4";
    wrPer(0);
    ticks(20);
    hardCheck("R4", 0, 0, 0);

    curReq = "R3";
    wrPer(1);
    ticks(1);
    hardCheck("R3", 0, 1, 1);
    curReq = "R8";
    step(1, 1, 0, 16'hE000);
    hardCheck("R8", 0, 1, 1);
    wrCtl(16'hE000);
    ticks(1);

    curReq = "R9";
    wrCtl(16'h2000);
    ticks(1);
    hardCheck("R9", 0, 0, 0);
    wrCtl(16'hC000);

    curReq = "R3";
    wrPer(1000);
    for (int i = 0; i < 999; i++) begin
      step(1, 0, 0, '0);
      step(0, 0, 0, '0);
    end
    hardCheck("R3", 999, 0, 0);
    ticks(1);
    hardCheck("R3", 0, 1, 1);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule